// File: doc/BRIEF.md
# Two-Phase Program Counter with Relative Branch

This block keeps the 15-bit program counter of a processor that spends two phases on every instruction. A one-bit phase input is low during the first phase, when the counter value addresses memory to fetch the instruction. It is high during the second phase, when the instruction executes. The counter may change only on a clock edge that ends the second phase. It therefore holds steady for the whole fetch.

Two control lines request the update: a step request and a load request. A load either takes an externally computed absolute target (jumps and subroutine calls) or, in relative mode, performs a conditional branch. A taken branch adds a sign-extended offset to the current counter. A branch whose tested flag is clear advances the counter by one instead. All arithmetic wraps modulo 2^15. The counter value is a registered output and drives the fetch address directly.

Top module: `two_phase_pc`

## Requirements
- R1: While `rst` is high on a rising clock edge, `pc` becomes 0 after that edge; reset is synchronous and active high.
- R2: On an edge where `phase_two` is 0 (first phase), `pc` does not change, whatever the request inputs are.
- R3: On a second-phase edge with `inc_req`=1 and `load_req`=0, `pc` becomes the old `pc` plus one.
- R4: On a second-phase edge with `load_req`=1, `inc_req`=0 and `rel_branch`=0, `pc` becomes `jump_target`.
- R5: On a second-phase edge with `load_req`=1, `inc_req`=0, `rel_branch`=1 and `flag_hit`=1, `pc` becomes the old `pc` plus `branch_ofs`, where `branch_ofs` is read as a two's-complement number (bit 8 is the sign).
- R6: On a second-phase edge with `load_req`=1, `inc_req`=0, `rel_branch`=1 and `flag_hit`=0, `pc` becomes the old `pc` plus one.
- R7: On a second-phase edge with both `inc_req` and `load_req` at 0, `pc` holds its value.
- R8: Every sum wraps modulo 2^15: stepping from 0x7FFF gives 0, and a negative offset from a small `pc` wraps to the top of the range.
- R9: Both requests high together are legal only in the first phase, where they change nothing. In the second phase this combination is illegal and flagged; the counter then holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_two | input | 1 | 0 = fetch phase, 1 = execute phase |
| inc_req | input | 1 | Request to advance the counter by one |
| load_req | input | 1 | Request to load a new counter value |
| rel_branch | input | 1 | With a load: 1 = relative branch, 0 = absolute target |
| flag_hit | input | 1 | The flag tested by the branch is set |
| jump_target | input | 15 | Absolute target for a non-relative load |
| branch_ofs | input | 9 | Signed branch offset |
| pc | output | 15 | Current program counter (fetch address) |

## Verification
The load path and the step path can both produce the next counter value in the same cycle. A relative branch whose flag is clear resolves to a step, and both requests may be raised together during the fetch phase. The bench provokes both cases: untaken branches and double requests in the first phase, mixed into a long pseudo-random run whose phase alternates every cycle. A behavioural model predicts the counter after every edge, and a result counts as correct only when the step, the branch sum or the hold matches exactly. Double requests in the second phase are never driven, because an assertion declares them illegal.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Next-value source selected for the program counter
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_JUMP = 2'd2,
    PC_REL  = 2'd3
  } pc_sel_e;

endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic    phase_two,
  input  logic    inc_req,
  input  logic    load_req,
  input  logic    rel_branch,
  input  logic    flag_hit,
  output pc_sel_e sel
);

  always_comb begin
    sel = PC_HOLD;
    if (phase_two) begin
      unique case ({inc_req, load_req})
        2'b10:   sel = PC_STEP;
        2'b01: begin
          if (!rel_branch)   sel = PC_JUMP;
          else if (flag_hit) sel = PC_REL;
          else               sel = PC_STEP;
        end
        default: sel = PC_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/pc_offset_ext.sv
module pc_offset_ext #(
  parameter int PC_W  = 15,
  parameter int OFS_W = 9
) (
  input  logic [OFS_W-1:0] ofs_in,
  output logic [PC_W-1:0]  ofs_ext
);

  generate
    if (OFS_W < PC_W) begin : g_extend
      localparam int PadW = PC_W - OFS_W;
      assign ofs_ext = {{PadW{ofs_in[OFS_W-1]}}, ofs_in};
    end else begin : g_trim
      assign ofs_ext = ofs_in[PC_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
#(
  parameter int PC_W = 15
) (
  input  pc_sel_e          sel,
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [PC_W-1:0]  target,
  input  logic [PC_W-1:0]  ofs_ext,
  output logic [PC_W-1:0]  pc_nxt,
  output logic             upd
);

  localparam logic [PC_W-1:0] One = PC_W'(1);

  logic [PC_W-1:0] addend;

  // One shared adder serves both the step and the relative branch
  always_comb begin
    addend = (sel == PC_REL) ? ofs_ext : One;
    unique case (sel)
      PC_JUMP: pc_nxt = target;
      PC_HOLD: pc_nxt = pc_cur;
      default: pc_nxt = pc_cur + addend;
    endcase
    upd = (sel != PC_HOLD);
  end

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int              PC_W     = 15,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            phase_two,
  input  logic            upd,
  input  logic [PC_W-1:0] pc_nxt,
  output logic [PC_W-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (rst)      pc_q <= RESET_PC;
    else if (upd) pc_q <= pc_nxt;
  end

  // R1: reset loads the reset value
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> pc_q == RESET_PC);

  // R2: no change across a first-phase edge
  a_r2_fetch_stable: assert property (@(posedge clk) disable iff (rst)
    !phase_two |=> $stable(pc_q));

endmodule

// File: rtl/two_phase_pc.sv
module two_phase_pc
  import pc_pkg::*;
#(
  parameter int              PC_W     = 15,
  parameter int              OFS_W    = 9,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_two,
  input  logic              inc_req,
  input  logic              load_req,
  input  logic              rel_branch,
  input  logic              flag_hit,
  input  logic [PC_W-1:0]   jump_target,
  input  logic [OFS_W-1:0]  branch_ofs,
  output logic [PC_W-1:0]   pc
);

  pc_sel_e         sel;
  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] pc_nxt;
  logic            upd;

  pc_ctrl u_ctrl (
    .phase_two  (phase_two),
    .inc_req    (inc_req),
    .load_req   (load_req),
    .rel_branch (rel_branch),
    .flag_hit   (flag_hit),
    .sel        (sel)
  );

  pc_offset_ext #(.PC_W(PC_W), .OFS_W(OFS_W)) u_ext (
    .ofs_in  (branch_ofs),
    .ofs_ext (ofs_ext)
  );

  pc_next #(.PC_W(PC_W)) u_next (
    .sel     (sel),
    .pc_cur  (pc),
    .target  (jump_target),
    .ofs_ext (ofs_ext),
    .pc_nxt  (pc_nxt),
    .upd     (upd)
  );

  pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .phase_two (phase_two),
    .upd       (upd),
    .pc_nxt    (pc_nxt),
    .pc_q      (pc)
  );

  // R3 and R8: step adds one, wrapping at the top
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (phase_two && inc_req && !load_req) |=> pc == PC_W'($past(pc) + 1));

  // R4: absolute load
  a_r4_jump: assert property (@(posedge clk) disable iff (rst)
    (phase_two && load_req && !inc_req && !rel_branch) |=> pc == $past(jump_target));

  // R6: untaken branch falls back to a step
  a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
    (phase_two && load_req && !inc_req && rel_branch && !flag_hit)
      |=> pc == PC_W'($past(pc) + 1));

  // R7: no request, no change
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_two && !inc_req && !load_req) |=> $stable(pc));

  // R9: both requests in the execute phase are illegal
  a_r9_dual_request: assert property (@(posedge clk) disable iff (rst)
    phase_two |-> !(inc_req && load_req));

endmodule

// File: tb/sim_two_phase_pc.sv
module sim_two_phase_pc;

  localparam int PC_W  = 15;
  localparam int OFS_W = 9;
  localparam int MASK  = (1 << PC_W) - 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             phase_two;
  logic             inc_req;
  logic             load_req;
  logic             rel_branch;
  logic             flag_hit;
  logic [PC_W-1:0]  jump_target;
  logic [OFS_W-1:0] branch_ofs;
  logic [PC_W-1:0]  pc;

  int checks = 0;
  int errors = 0;
  int expected = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  two_phase_pc u0 (
    .clk(clk), .rst(rst), .phase_two(phase_two), .inc_req(inc_req),
    .load_req(load_req), .rel_branch(rel_branch), .flag_hit(flag_hit),
    .jump_target(jump_target), .branch_ofs(branch_ofs), .pc(pc)
  );

  function automatic int sext(input logic [OFS_W-1:0] v);
    int r;
    r = int'(v);
    if (v[OFS_W-1]) r = r - (1 << OFS_W);
    return r;
  endfunction

  // Reference model of one clock edge, taken from the requirements
  function automatic int model(input int cur);
    if (rst) return 0;
    if (!phase_two) return cur;
    if (inc_req && !load_req) return (cur + 1) & MASK;
    if (load_req && !inc_req) begin
      if (!rel_branch) return int'(jump_target);
      if (flag_hit) return (cur + sext(branch_ofs)) & MASK;
      return (cur + 1) & MASK;
    end
    return cur;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (int'(pc) != expected) begin
      errors++;
      $display("FAIL %s: pc=%h expected=%h", tag, pc, expected[PC_W-1:0]);
    end
  endtask

  task automatic cyc(input logic ph, input logic inc, input logic ld,
                     input logic rel, input logic fl, input int tgt,
                     input int ofs, input string tag);
    phase_two   = ph;
    inc_req     = inc;
    load_req    = ld;
    rel_branch  = rel;
    flag_hit    = fl;
    jump_target = tgt[PC_W-1:0];
    branch_ofs  = ofs[OFS_W-1:0];
    @(posedge clk);
    expected = model(expected);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    rst = 1'b1;
    phase_two = 0; inc_req = 0; load_req = 0; rel_branch = 0; flag_hit = 0;
    jump_target = '0; branch_ofs = '0;
    @(posedge clk);
    expected = 0;
    @(negedge clk);
    check("R1 reset");
    cyc(0, 0, 0, 0, 0, 0, 0, "R1 reset held");
    rst = 1'b0;

    cyc(0, 1, 0, 0, 0, 0, 0, "R2 fetch-phase step ignored");
    cyc(0, 0, 1, 0, 0, 'h1234, 0, "R2 fetch-phase load ignored");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3 step");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3 second step");
    cyc(1, 0, 1, 0, 0, 'h1234, 0, "R4 absolute load");
    cyc(1, 0, 1, 1, 1, 'h0555, 5, "R5 branch taken forward");
    cyc(1, 0, 1, 1, 1, 'h0555, -3, "R5 branch taken backward");
    cyc(1, 0, 1, 1, 0, 'h0555, 40, "R6 branch not taken");
    cyc(1, 0, 0, 1, 1, 'h0555, 40, "R7 idle hold");
    cyc(0, 1, 1, 1, 1, 'h0555, 40, "R9 both requests in fetch phase");
    cyc(1, 0, 1, 0, 0, 'h7FFF, 0, "R4 load top value");
    cyc(1, 1, 0, 0, 0, 0, 0, "R8 step wraps to zero");
    cyc(1, 0, 1, 1, 1, 0, -1, "R8 negative offset wraps");
    cyc(1, 0, 1, 1, 1, 0, 255, "R8 largest forward offset wraps");
    cyc(1, 0, 1, 1, 1, 0, -256, "R5 most negative offset");

    rst = 1'b1;
    cyc(1, 1, 0, 0, 0, 0, 0, "R1 reset over step");
    rst = 1'b0;

    begin
      logic [15:0] lf = 16'hACE1;
      logic ph = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        logic inc, ld;
        string tag;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        inc = lf[0];
        ld  = lf[1];
        if (ph && inc && ld) inc = 1'b0;
        if (!ph)             tag = (inc && ld) ? "R9 random" : "R2 random";
        else if (inc)        tag = "R3 random";
        else if (!ld)        tag = "R7 random";
        else if (!lf[2])     tag = "R4 random";
        else if (lf[3])      tag = "R5 random";
        else                 tag = "R6 random";
        cyc(ph, inc, ld, lf[2], lf[3], int'({lf[14:0]}),
            int'({lf[15:8], lf[4]}), tag);
        ph = ~ph;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule